// File: doc/BRIEF.md
# Synchronous SRAM Write and Output Control

This block sits between the pins of a pipelined 32-bit synchronous SRAM and its storage array. On every rising clock edge it decodes the control inputs: a global write, a byte-write enable with its per-byte selects, the processor address strobe and three chip-select terms. It then registers a command for the array. A write becomes a set of per-byte strobes, together with registered address and data, in the following cycle. A read becomes registered output data one edge after the address is taken.

The block also decides when the data drivers may be on. The output enable acts asynchronously. Any live byte write turns the drivers off. Deselection switches them off within a single cycle. When a read is accepted right after an edge at which chip enable was inactive, which is the usual case when two banks share a bus and alternate, the drivers stay off for that first word.

A sleep input freezes every internal register and blocks all array writes, so stored data is kept. The array is external and is read combinationally at the registered address.

Top module: `ssram_wrctl`

## Requirements
- R1: A low `gwr_n_i` at an edge while selected writes all bytes. It ignores `bwen_n_i`, `bsel_n_i` and `astb_n_i`.
- R2: With `gwr_n_i` high, byte b is written only if `bwen_n_i` is low and `bsel_n_i[b]` is low. `bsel_n_i[0]` controls data bits 7:0, `bsel_n_i[1]` bits 15:8, `bsel_n_i[2]` bits 23:16 and `bsel_n_i[3]` bits 31:24. With `bwen_n_i` high the byte selects have no effect.
- R3: A low `astb_n_i` at an edge blocks all byte writes of that cycle. The selected cycle is then treated as a read.
- R4: The block is selected only when `cen_n_i` is low, `csel_hi_i` is high and `csel_lo_n_i` is low. An unselected edge starts neither a write nor a read.
- R5: The write strobes, data and address of a write accepted at edge k are on `arr_wstrb_o`, `arr_wdata_o` and `arr_addr_o` between edges k and k+1. The array commits them at edge k+1.
- R6: A read accepted at edge k places the array word on `dout_o` at edge k+1. If `cen_n_i` was low at edge k-1, `drive_o` rises at edge k+1 as well.
- R7: While any write strobe is active, `drive_o` is low.
- R8: `oe_n_i` high forces `drive_o` low without waiting for a clock edge.
- R9: After a read at edge k and an unselected edge k+1, `drive_o` is low after edge k+2.
- R10: With `BANK_DLY`=1, a read accepted at an edge following one where `cen_n_i` was high gets valid `dout_o` at the next edge but `drive_o` stays low for that word. The next read word is driven.
- R11: While `sleep_i` is high, all registers hold their values, `arr_wstrb_o` is zero and `drive_o` is low. Commands presented during sleep are lost, and array contents are retained.
- R12: After reset `arr_wstrb_o` is zero, `drive_o` is low and `dout_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Freeze internal state and block writes |
| cen_n_i | input | 1 | Chip enable, active low |
| csel_hi_i | input | 1 | Chip select, active high |
| csel_lo_n_i | input | 1 | Chip select, active low |
| astb_n_i | input | 1 | Processor address strobe, active low; vetoes byte writes |
| gwr_n_i | input | 1 | Global write, active low |
| bwen_n_i | input | 1 | Byte-write enable, active low |
| bsel_n_i | input | DW/8 | Per-byte write selects, active low |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| addr_i | input | AW | Access address |
| wdata_i | input | DW | Write data from the bus |
| arr_rdata_i | input | DW | Array word at `arr_addr_o` |
| arr_addr_o | output | AW | Registered array address |
| arr_wdata_o | output | DW | Registered write data |
| arr_wstrb_o | output | DW/8 | Per-byte write strobes to the array |
| dout_o | output | DW | Registered read data |
| drive_o | output | 1 | Data driver enable |

## Verification
The hardest case to reach is the bank-switch hold. It only appears when a read is accepted at the edge right after one where chip enable was inactive. Idle cycles in the other tests therefore deselect through `csel_hi_i`, which keeps chip enable low so that no hold is triggered by accident. The bank test then deselects through `cen_n_i` for a single edge and follows it with two back-to-back reads. This shows both the undriven first word and the driven second word. The write-versus-read overlap is reached by issuing a write at the very edge where the previous read's data lands.

// File: rtl/ssram_ctl_pkg.sv
package ssram_ctl_pkg;
   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } ssram_op_e;

   function automatic logic bank_hit(input logic cen_n, input logic hi, input logic lo_n);
      return !cen_n && hi && !lo_n;
   endfunction
endpackage

// File: rtl/ssram_wr_decode.sv
module ssram_wr_decode import ssram_ctl_pkg::*; #(
   parameter int NB = 4
) (
   input  logic          sel_i,
   input  logic          gwr_n_i,
   input  logic          bwen_n_i,
   input  logic          astb_n_i,
   input  logic [NB-1:0] bsel_n_i,
   output logic [NB-1:0] wmask_o,
   output ssram_op_e     op_o
);
   // byte path: enabled by bwen, vetoed by processor strobe
   logic byte_path;
   assign byte_path = !bwen_n_i && astb_n_i;

   for (genvar b = 0; b < NB; b++) begin : g_byte
      assign wmask_o[b] = sel_i && (!gwr_n_i || (byte_path && !bsel_n_i[b]));
   end

   always_comb begin
      if (!sel_i)        op_o = OP_NONE;
      else if (|wmask_o) op_o = OP_WRITE;
      else               op_o = OP_READ;
   end
endmodule

// File: rtl/ssram_cmd_reg.sv
module ssram_cmd_reg import ssram_ctl_pkg::*; #(
   parameter int AW = 15,
   parameter int DW = 32,
   parameter int NB = DW / 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_i,
   input  ssram_op_e     op_i,
   input  logic [NB-1:0] wmask_i,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] wdata_i,
   input  logic          cen_n_i,
   output ssram_op_e     op_q_o,
   output logic [NB-1:0] wmask_q_o,
   output logic [AW-1:0] addr_q_o,
   output logic [DW-1:0] wdata_q_o,
   output logic          fresh_q_o
);
   ssram_op_e     op_q;
   logic [NB-1:0] wmask_q;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] wdata_q;
   logic          fresh_q;
   logic          cen_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q       <= OP_NONE;
         wmask_q    <= '0;
         addr_q     <= '0;
         wdata_q    <= '0;
         fresh_q    <= 1'b0;
         cen_prev_q <= 1'b0;
      end else if (run_i) begin
         op_q       <= op_i;
         wmask_q    <= wmask_i;
         if (op_i != OP_NONE) addr_q <= addr_i;
         if (op_i == OP_WRITE) wdata_q <= wdata_i;
         fresh_q    <= (op_i == OP_READ) && cen_prev_q;
         cen_prev_q <= cen_n_i;
      end
   end

   assign op_q_o    = op_q;
   assign wmask_q_o = wmask_q;
   assign addr_q_o  = addr_q;
   assign wdata_q_o = wdata_q;
   assign fresh_q_o = fresh_q;
endmodule

// File: rtl/ssram_out_ctl.sv
module ssram_out_ctl #(
   parameter int DW       = 32,
   parameter bit BANK_DLY = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_i,
   input  logic          rd_pend_i,
   input  logic          fresh_i,
   input  logic          wr_live_i,
   input  logic          oe_n_i,
   input  logic [DW-1:0] rdata_i,
   output logic [DW-1:0] dout_o,
   output logic          drive_o
);
   logic [DW-1:0] dout_q;
   logic          vld_q;
   logic          hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q <= '0;
         vld_q  <= 1'b0;
      end else if (run_i) begin
         vld_q <= rd_pend_i;
         if (rd_pend_i) dout_q <= rdata_i;
      end
   end

   if (BANK_DLY) begin : g_bank_dly
      logic hold_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     hold_q <= 1'b0;
         else if (run_i) hold_q <= rd_pend_i && fresh_i;
      end
      assign hold = hold_q;
   end else begin : g_no_dly
      logic unused_fresh;
      assign unused_fresh = fresh_i;
      assign hold = 1'b0;
   end

   assign dout_o  = dout_q;
   assign drive_o = vld_q && !hold && !wr_live_i && !oe_n_i && run_i;
endmodule

// File: rtl/ssram_wrctl.sv
module ssram_wrctl import ssram_ctl_pkg::*; #(
   parameter int AW       = 15,
   parameter int DW       = 32,
   parameter bit BANK_DLY = 1'b1,
   localparam int NB      = DW / 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sleep_i,
   input  logic          cen_n_i,
   input  logic          csel_hi_i,
   input  logic          csel_lo_n_i,
   input  logic          astb_n_i,
   input  logic          gwr_n_i,
   input  logic          bwen_n_i,
   input  logic [NB-1:0] bsel_n_i,
   input  logic          oe_n_i,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] wdata_i,
   input  logic [DW-1:0] arr_rdata_i,
   output logic [AW-1:0] arr_addr_o,
   output logic [DW-1:0] arr_wdata_o,
   output logic [NB-1:0] arr_wstrb_o,
   output logic [DW-1:0] dout_o,
   output logic          drive_o
);
   if (DW % 8 != 0 || DW < 8) begin : g_bad_dw
      $error("ssram_wrctl: DW must be a positive multiple of 8");
   end
   if (AW < 1) begin : g_bad_aw
      $error("ssram_wrctl: AW must be at least 1");
   end

   logic          run;
   logic          sel;
   logic [NB-1:0] wmask;
   ssram_op_e     op;
   ssram_op_e     op_q;
   logic [NB-1:0] wmask_q;
   logic          fresh_q;

   assign run = !sleep_i;
   assign sel = bank_hit(cen_n_i, csel_hi_i, csel_lo_n_i);

   ssram_wr_decode #(.NB(NB)) u_dec (
      .sel_i    (sel),
      .gwr_n_i  (gwr_n_i),
      .bwen_n_i (bwen_n_i),
      .astb_n_i (astb_n_i),
      .bsel_n_i (bsel_n_i),
      .wmask_o  (wmask),
      .op_o     (op)
   );

   ssram_cmd_reg #(.AW(AW), .DW(DW), .NB(NB)) u_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (run),
      .op_i      (op),
      .wmask_i   (wmask),
      .addr_i    (addr_i),
      .wdata_i   (wdata_i),
      .cen_n_i   (cen_n_i),
      .op_q_o    (op_q),
      .wmask_q_o (wmask_q),
      .addr_q_o  (arr_addr_o),
      .wdata_q_o (arr_wdata_o),
      .fresh_q_o (fresh_q)
   );

   assign arr_wstrb_o = wmask_q & {NB{run}};

   ssram_out_ctl #(.DW(DW), .BANK_DLY(BANK_DLY)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (run),
      .rd_pend_i (op_q == OP_READ),
      .fresh_i   (fresh_q),
      .wr_live_i (|arr_wstrb_o),
      .oe_n_i    (oe_n_i),
      .rdata_i   (arr_rdata_i),
      .dout_o    (dout_o),
      .drive_o   (drive_o)
   );
endmodule

// File: rtl/ssram_wrctl_chk.sv
module ssram_wrctl_chk #(
   parameter int DW = 32,
   localparam int NB = DW / 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sleep_i,
   input logic          cen_n_i,
   input logic          csel_hi_i,
   input logic          csel_lo_n_i,
   input logic          astb_n_i,
   input logic          gwr_n_i,
   input logic          bwen_n_i,
   input logic          oe_n_i,
   input logic [NB-1:0] arr_wstrb_o,
   input logic [DW-1:0] dout_o,
   input logic          drive_o
);
   logic sel;
   assign sel = !cen_n_i && csel_hi_i && !csel_lo_n_i;

   a_r1_global_all: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && !gwr_n_i && !sleep_i) |=> (sleep_i || arr_wstrb_o == {NB{1'b1}}));

   a_r2_bwen_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && gwr_n_i && bwen_n_i && !sleep_i) |=> (arr_wstrb_o == '0));

   a_r3_strobe_veto: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && gwr_n_i && !astb_n_i && !sleep_i) |=> (arr_wstrb_o == '0));

   a_r4_unselected: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel && !sleep_i) |=> (arr_wstrb_o == '0));

   a_r7_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (|arr_wstrb_o) |-> !drive_o);

   a_r8_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n_i |-> !drive_o);

   a_r11_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_i |-> (arr_wstrb_o == '0 && !drive_o));

   a_r11_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_i |=> $stable(dout_o));
endmodule

bind ssram_wrctl ssram_wrctl_chk #(.DW(DW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sleep_i     (sleep_i),
   .cen_n_i     (cen_n_i),
   .csel_hi_i   (csel_hi_i),
   .csel_lo_n_i (csel_lo_n_i),
   .astb_n_i    (astb_n_i),
   .gwr_n_i     (gwr_n_i),
   .bwen_n_i    (bwen_n_i),
   .oe_n_i      (oe_n_i),
   .arr_wstrb_o (arr_wstrb_o),
   .dout_o      (dout_o),
   .drive_o     (drive_o)
);

// File: tb/ssram_wrctl_bench.sv
module ssram_wrctl_bench;
   localparam int AW = 4;
   localparam int DW = 32;
   localparam int NB = DW / 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sleep_i = 1'b0;
   logic          cen_n_i, csel_hi_i, csel_lo_n_i, astb_n_i, gwr_n_i, bwen_n_i;
   logic [NB-1:0] bsel_n_i;
   logic          oe_n_i = 1'b0;
   logic [AW-1:0] addr_i;
   logic [DW-1:0] wdata_i;
   logic [DW-1:0] arr_rdata_i;
   logic [AW-1:0] arr_addr_o;
   logic [DW-1:0] arr_wdata_o;
   logic [NB-1:0] arr_wstrb_o;
   logic [DW-1:0] dout_o;
   logic          drive_o;

   int checks = 0;
   int errors = 0;

   logic [DW-1:0] mem [1 << AW];

   always #2 clk = ~clk;

   ssram_wrctl #(.AW(AW), .DW(DW), .BANK_DLY(1'b1)) u_ssram_wrctl (
      .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .cen_n_i(cen_n_i),
      .csel_hi_i(csel_hi_i), .csel_lo_n_i(csel_lo_n_i), .astb_n_i(astb_n_i),
      .gwr_n_i(gwr_n_i), .bwen_n_i(bwen_n_i), .bsel_n_i(bsel_n_i),
      .oe_n_i(oe_n_i), .addr_i(addr_i), .wdata_i(wdata_i),
      .arr_rdata_i(arr_rdata_i), .arr_addr_o(arr_addr_o),
      .arr_wdata_o(arr_wdata_o), .arr_wstrb_o(arr_wstrb_o),
      .dout_o(dout_o), .drive_o(drive_o)
   );

   // behavioural array
   assign arr_rdata_i = mem[arr_addr_o];
   always @(posedge clk) begin
      for (int b = 0; b < NB; b++)
         if (arr_wstrb_o[b]) mem[arr_addr_o][b*8 +: 8] <= arr_wdata_o[b*8 +: 8];
   end

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   // deselected via csel_hi so chip enable stays low
   task automatic drv_idle();
      cen_n_i = 1'b0; csel_hi_i = 1'b0; csel_lo_n_i = 1'b0;
      astb_n_i = 1'b1; gwr_n_i = 1'b1; bwen_n_i = 1'b1; bsel_n_i = '1;
      addr_i = '0; wdata_i = '0;
   endtask

   task automatic drv_sel(input logic [AW-1:0] a, input logic [DW-1:0] d);
      cen_n_i = 1'b0; csel_hi_i = 1'b1; csel_lo_n_i = 1'b0;
      astb_n_i = 1'b1; gwr_n_i = 1'b1; bwen_n_i = 1'b1; bsel_n_i = '1;
      addr_i = a; wdata_i = d;
   endtask

   task automatic read_check(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] exp);
      drv_sel(a, '0);
      step();
      drv_idle();
      step();
      chk({tag, " data"}, dout_o, exp);
      chk({tag, " drive"}, {31'b0, drive_o}, 1);
      step();
   endtask

   task automatic t_reset();
      chk("R12 strobes", {28'b0, arr_wstrb_o}, 0);
      chk("R12 drive", {31'b0, drive_o}, 0);
      chk("R12 dout", dout_o, 0);
   endtask

   task automatic t_global();
      drv_sel(4'd1, 32'hA5A5_1234);
      gwr_n_i = 1'b0; bwen_n_i = 1'b0; astb_n_i = 1'b0; bsel_n_i = 4'b1111;
      step();
      chk("R1 all strobes", {28'b0, arr_wstrb_o}, 32'hF);
      chk("R5 wdata", arr_wdata_o, 32'hA5A5_1234);
      chk("R5 addr", {28'b0, arr_addr_o}, 1);
      drv_idle();
      step();
      chk("R5 strobes cleared", {28'b0, arr_wstrb_o}, 0);
      chk("R5 committed", mem[1], 32'hA5A5_1234);
      drv_sel(4'd1, '0);
      step();
      drv_idle();
      step();
      chk("R6 read data", dout_o, 32'hA5A5_1234);
      chk("R6 drive", {31'b0, drive_o}, 1);
      step();
      chk("R9 deselect off", {31'b0, drive_o}, 0);
   endtask

   task automatic t_bytes();
      drv_sel(4'd2, 32'h0);
      gwr_n_i = 1'b0;
      step();
      drv_idle();
      step();
      drv_sel(4'd2, 32'h1122_3344);
      bwen_n_i = 1'b0; bsel_n_i = 4'b1010;
      step();
      chk("R2 byte strobes", {28'b0, arr_wstrb_o}, 32'h5);
      drv_idle();
      step();
      read_check("R2 merged", 4'd2, 32'h0022_0044);
      drv_sel(4'd2, 32'hFFFF_FFFF);
      bwen_n_i = 1'b1; bsel_n_i = 4'b0000;
      step();
      chk("R2 bwen high no strobe", {28'b0, arr_wstrb_o}, 0);
      drv_idle();
      step();
      read_check("R2 unchanged", 4'd2, 32'h0022_0044);
   endtask

   task automatic t_veto();
      drv_sel(4'd2, 32'hFFFF_FFFF);
      bwen_n_i = 1'b0; bsel_n_i = 4'b0000; astb_n_i = 1'b0;
      step();
      chk("R3 veto strobes", {28'b0, arr_wstrb_o}, 0);
      drv_idle();
      step();
      chk("R3 became read", dout_o, 32'h0022_0044);
      chk("R3 read driven", {31'b0, drive_o}, 1);
      step();
   endtask

   task automatic t_desel();
      for (int v = 0; v < 3; v++) begin
         drv_sel(4'd3, 32'hDEAD_0000 + v);
         gwr_n_i = 1'b0;
         if (v == 0) csel_hi_i = 1'b0;
         if (v == 1) csel_lo_n_i = 1'b1;
         if (v == 2) cen_n_i = 1'b1;
         step();
         chk("R4 no strobe", {28'b0, arr_wstrb_o}, 0);
         drv_idle();
         step();
         chk("R4 no read drive", {31'b0, drive_o}, 0);
      end
      read_check("R4 mem kept", 4'd3, 32'h0);
   endtask

   task automatic t_wr_quiet();
      drv_sel(4'd1, '0);
      step();
      drv_sel(4'd4, 32'h0BAD_F00D);
      gwr_n_i = 1'b0;
      step();
      chk("R7 data landed", dout_o, 32'hA5A5_1234);
      chk("R7 drive off", {31'b0, drive_o}, 0);
      drv_idle();
      step();
      read_check("R7 write done", 4'd4, 32'h0BAD_F00D);
   endtask

   task automatic t_oe();
      drv_sel(4'd1, '0);
      step();
      drv_idle();
      step();
      chk("R8 on", {31'b0, drive_o}, 1);
      oe_n_i = 1'b1;
      #1;
      chk("R8 async off", {31'b0, drive_o}, 0);
      oe_n_i = 1'b0;
      #1;
      chk("R8 async on", {31'b0, drive_o}, 1);
      step();
   endtask

   task automatic t_bank();
      drv_idle();
      cen_n_i = 1'b1;
      step();
      drv_sel(4'd4, '0);
      step();
      drv_sel(4'd1, '0);
      step();
      chk("R10 first data", dout_o, 32'h0BAD_F00D);
      chk("R10 first held", {31'b0, drive_o}, 0);
      drv_idle();
      step();
      chk("R10 second data", dout_o, 32'hA5A5_1234);
      chk("R10 second driven", {31'b0, drive_o}, 1);
      step();
   endtask

   task automatic t_sleep();
      drv_sel(4'd4, '0);
      step();
      drv_idle();
      step();
      sleep_i = 1'b1;
      drv_sel(4'd4, 32'h5555_AAAA);
      gwr_n_i = 1'b0;
      #1;
      chk("R11 drive off", {31'b0, drive_o}, 0);
      for (int i = 0; i < 3; i++) begin
         step();
         chk("R11 no strobe", {28'b0, arr_wstrb_o}, 0);
         chk("R11 dout held", dout_o, 32'h0BAD_F00D);
      end
      drv_idle();
      sleep_i = 1'b0;
      step();
      step();
      read_check("R11 retained", 4'd4, 32'h0BAD_F00D);
   endtask

   initial begin
      for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
      drv_idle();
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      t_reset();
      step();
      t_global();
      t_bytes();
      t_veto();
      t_desel();
      t_wr_quiet();
      t_oe();
      t_bank();
      t_sleep();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule